// File: doc/BRIEF.md
# Multiplexed Four-Digit Hex Display Driver

This block shows a 16-bit number as four hexadecimal characters on a seven-segment display. The display has a shared segment bus and one enable line per digit. A load strobe captures the number and starts a display session. During the session the block lights one digit at a time. Each digit stays lit for a parameterised number of clock cycles, and the enable is dropped for one cycle before the next digit is driven.

A session runs a fixed number of full four-digit passes and then stops. When it stops, all segments are turned off and a done flag is raised. The flag stays high until the next load. A blank input holds every digit enable low but leaves the session timer running, so a session ends in the same cycle whether or not it was blanked.

Top module: `hexscan_display`

## Requirements
- R1: After reset, `dig_en_o` is 0, `seg_o` is 7'h7F (all segments dark) and `done_o` is 0.
- R2: `value_i` is captured in the clock edge where `load_i` is high. Later changes on `value_i` do not alter the digits shown until the next load.
- R3: In the cycle after a load, the display starts at nibble 0 (bits 3:0), followed by nibble 1, nibble 2 and nibble 3. Each nibble occupies a slot of `DWELL_CYC` cycles. Nibble k is enabled on `dig_en_o` bit 3-k, and enables are active high.
- R4: At most one bit of `dig_en_o` is high in any cycle.
- R5: Segments are active low (0 lights a segment). The `seg_o` bits are: [0] top, [1] upper right, [2] lower right, [3] bottom, [4] lower left, [5] upper left, [6] middle. The lit segments for each value are:
  - 0: all except middle
  - 1: upper right and lower right
  - 2: top, upper right, middle, lower left, bottom
  - 3: top, upper right, middle, lower right, bottom
  - 4: upper left, middle, upper right, lower right
  - 5: top, upper left, middle, lower right, bottom
  - 6: all except upper right
  - 7: top, upper right, lower right
  - 8: all
  - 9: all except lower left
  - A: all except bottom
  - b: upper left, lower left, middle, bottom, lower right
  - C: top, upper left, lower left, bottom
  - d: upper right, lower right, middle, lower left, bottom
  - E: all except upper right and lower right
  - F: top, upper left, middle, lower left
- R6: In the last cycle of every slot, `dig_en_o` is 0 and `seg_o` is 7'h7F.
- R7: A session lasts exactly `PASSES` full passes, which is 4*`DWELL_CYC`*`PASSES` cycles. After that, `dig_en_o` is 0, `seg_o` is 7'h7F and `done_o` is 1.
- R8: `done_o` stays high until a load. A load clears `done_o` from the next cycle on.
- R9: While `blank_i` is high, `dig_en_o` is 0 in that same cycle. `seg_o` and the session timing are unaffected.
- R10: A load during a session restarts the session at nibble 0 of pass 0 with the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| value_i | input | 16 | Number to display |
| load_i | input | 1 | Capture value and start a session |
| blank_i | input | 1 | Hold all digit enables low |
| dig_en_o | output | 4 | Digit enables, active high; bit 3 = least significant digit |
| seg_o | output | 7 | Segment bus, active low |
| done_o | output | 1 | Session finished |

## Verification
Some properties are checked by assertions in every cycle:
- at most one digit enable is high;
- the gap cycle at the end of each slot is dark;
- blank forces the enables low;
- the display is idle while done is high;
- done holds until a load, and a load clears it;
- the digit index steps forward in order.

Other behaviour is shown only by the bench scenarios, which compare every output cycle of whole sessions against expected values:
- the glyph shapes;
- the reversed mapping from nibble to enable line;
- value capture despite later input changes;
- the exact session length, with and without blanking;
- a restart in the middle of a session.

// File: rtl/hexscan_pkg.sv
package hexscan_pkg;

  // Active-low glyph; bit 0 top, 1 upper right, 2 lower right, 3 bottom,
  // 4 lower left, 5 upper left, 6 middle.
  function automatic logic [6:0] glyph7(input logic [3:0] nib);
    logic [6:0] g;
    case (nib)
      4'h0: g = 7'h40;
      4'h1: g = 7'h79;
      4'h2: g = 7'h24;
      4'h3: g = 7'h30;
      4'h4: g = 7'h19;
      4'h5: g = 7'h12;
      4'h6: g = 7'h02;
      4'h7: g = 7'h78;
      4'h8: g = 7'h00;
      4'h9: g = 7'h10;
      4'hA: g = 7'h08;
      4'hB: g = 7'h03;
      4'hC: g = 7'h46;
      4'hD: g = 7'h21;
      4'hE: g = 7'h06;
      default: g = 7'h0E;
    endcase
    return g;
  endfunction

  // Nibble k drives enable bit 3-k.
  function automatic logic [3:0] enable_for(input logic [1:0] idx);
    return 4'b1000 >> idx;
  endfunction

  localparam logic [6:0] SEG_DARK = 7'h7F;

endpackage

// File: rtl/hexscan_timer.sv
module hexscan_timer #(
  parameter int DWELL_CYC = 2500,
  parameter int PASSES    = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic       active_o,
  output logic [1:0] digit_o,
  output logic       slot_last_o,
  output logic       session_end_o
);
  localparam int CNT_W  = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1;
  localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(DWELL_CYC - 1);
  localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(PASSES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [PASS_W-1:0] pass_q;
  logic [1:0]        digit_q;
  logic              active_q;

  assign slot_last_o   = active_q && (cnt_q == CNT_LAST);
  assign session_end_o = slot_last_o && (digit_q == 2'd3) && (pass_q == PASS_LAST);
  assign active_o      = active_q;
  assign digit_o       = digit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      pass_q   <= '0;
      digit_q  <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= '0;
      pass_q   <= '0;
      digit_q  <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (slot_last_o) begin
        cnt_q   <= '0;
        digit_q <= digit_q + 2'd1;
        if (digit_q == 2'd3) pass_q <= pass_q + 1'b1;
        if (session_end_o) active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3: digit index advances by one at each slot boundary
  p_digit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_last_o && !session_end_o && !start_i) |=> (digit_o == $past(digit_o) + 2'd1));

  // R7: counter never leaves its range while active
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q <= CNT_LAST && pass_q <= PASS_LAST));

endmodule

// File: rtl/hexscan_drive.sv
module hexscan_drive
  import hexscan_pkg::*;
(
  input  logic        active_i,
  input  logic        slot_last_i,
  input  logic        blank_i,
  input  logic [1:0]  digit_i,
  input  logic [15:0] value_i,
  output logic [3:0]  dig_en_o,
  output logic [6:0]  seg_o
);
  logic [3:0] nib_w;
  logic       lit_w;

  assign nib_w    = value_i[{digit_i, 2'b00} +: 4];
  assign lit_w    = active_i && !slot_last_i;
  assign seg_o    = lit_w ? glyph7(nib_w) : SEG_DARK;
  assign dig_en_o = (lit_w && !blank_i) ? enable_for(digit_i) : 4'b0000;

  // R9: blank never lets an enable through
  p_blank_dark_r9: assert final (!(blank_i && dig_en_o != 4'b0000));

endmodule

// File: rtl/hexscan_display.sv
module hexscan_display
  import hexscan_pkg::*;
#(
  parameter int DWELL_CYC = 2500,
  parameter int PASSES    = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] value_i,
  input  logic        load_i,
  input  logic        blank_i,
  output logic [3:0]  dig_en_o,
  output logic [6:0]  seg_o,
  output logic        done_o
);
  logic [15:0] value_q;
  logic        done_q;
  logic        active_w;
  logic [1:0]  digit_w;
  logic        slot_last_w;
  logic        session_end_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value_q <= '0;
    else if (load_i) value_q <= value_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             done_q <= 1'b0;
    else if (load_i)        done_q <= 1'b0;
    else if (session_end_w) done_q <= 1'b1;
  end

  assign done_o = done_q;

  hexscan_timer #(.DWELL_CYC(DWELL_CYC), .PASSES(PASSES)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (load_i),
    .active_o      (active_w),
    .digit_o       (digit_w),
    .slot_last_o   (slot_last_w),
    .session_end_o (session_end_w)
  );

  hexscan_drive u_drive (
    .active_i    (active_w),
    .slot_last_i (slot_last_w),
    .blank_i     (blank_i),
    .digit_i     (digit_w),
    .value_i     (value_q),
    .dig_en_o    (dig_en_o),
    .seg_o       (seg_o)
  );

  p_onehot_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dig_en_o));

  p_slot_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_last_w |-> (dig_en_o == 4'b0000 && seg_o == SEG_DARK));

  p_blank_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blank_i |-> (dig_en_o == 4'b0000));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (dig_en_o == 4'b0000 && seg_o == SEG_DARK));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> done_o);

  p_load_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !done_o);

endmodule

// File: tb/hexscan_display_tb.sv
module hexscan_display_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 5;
  localparam int NP = 3;
  localparam int TOTAL = 4 * DW * NP;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] value_i = '0;
  logic        load_i = 1'b0;
  logic        blank_i = 1'b0;
  logic [3:0]  dig_en_o;
  logic [6:0]  seg_o;
  logic        done_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hexscan_display #(.DWELL_CYC(DW), .PASSES(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .value_i(value_i), .load_i(load_i),
    .blank_i(blank_i), .dig_en_o(dig_en_o), .seg_o(seg_o), .done_o(done_o)
  );

  // Segment masks (bit position from R5)
  localparam logic [6:0] S_T = 7'h01, S_UR = 7'h02, S_LR = 7'h04, S_B = 7'h08,
                         S_LL = 7'h10, S_UL = 7'h20, S_M = 7'h40;

  function automatic logic [6:0] exp_glyph(input logic [3:0] n);
    logic [6:0] lit;
    case (n)
      4'h0: lit = S_T|S_UR|S_LR|S_B|S_LL|S_UL;
      4'h1: lit = S_UR|S_LR;
      4'h2: lit = S_T|S_UR|S_M|S_LL|S_B;
      4'h3: lit = S_T|S_UR|S_M|S_LR|S_B;
      4'h4: lit = S_UL|S_M|S_UR|S_LR;
      4'h5: lit = S_T|S_UL|S_M|S_LR|S_B;
      4'h6: lit = 7'h7F & ~S_UR;
      4'h7: lit = S_T|S_UR|S_LR;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h7F & ~S_LL;
      4'hA: lit = 7'h7F & ~S_B;
      4'hB: lit = S_UL|S_LL|S_M|S_B|S_LR;
      4'hC: lit = S_T|S_UL|S_LL|S_B;
      4'hD: lit = S_UR|S_LR|S_M|S_LL|S_B;
      4'hE: lit = 7'h7F & ~(S_UR|S_LR);
      default: lit = S_T|S_UL|S_M|S_LL;
    endcase
    return ~lit;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // blank_mode: 0 off, 1 always, 2 random per cycle. stop_at<TOTAL cuts short.
  task automatic run_session(input logic [15:0] val, input int blank_mode, input int stop_at);
    @(negedge clk);
    load_i = 1'b1;
    value_i = val;
    @(negedge clk);
    load_i = 1'b0;
    value_i = 16'($urandom);  // R2: input changes must not show
    chk(done_o == 1'b0, "R8 done cleared by load", done_o, 0);
    for (int i = 0; i < stop_at; i++) begin
      int c = i % DW;
      int d = (i / DW) % 4;
      bit gap = (c == DW - 1);
      logic [3:0] en_e;
      logic [6:0] sg_e;
      blank_i = (blank_mode == 1) ? 1'b1 : (blank_mode == 2) ? 1'($urandom % 2) : 1'b0;
      #1;
      sg_e = gap ? 7'h7F : exp_glyph(4'((val >> (4 * d)) & 16'hF));
      en_e = (gap || blank_i) ? 4'b0000 : 4'(1 << (3 - d));
      chk(seg_o == sg_e, "R5/R2/R6 segments", seg_o, sg_e);
      chk(dig_en_o == en_e, blank_i ? "R9 blank enables" : "R3/R6 digit enable", dig_en_o, en_e);
      if (i > 0) chk(done_o == 1'b0, "R7 done not early", done_o, 0);
      @(negedge clk);
      value_i = 16'($urandom);
    end
    blank_i = 1'b0;
    if (stop_at == TOTAL) begin
      #1;
      chk(done_o == 1'b1, "R7 done after session", done_o, 1);
      chk(dig_en_o == 4'b0 && seg_o == 7'h7F, "R7 idle outputs", {dig_en_o, seg_o}, 16'h7F);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(done_o == 1'b1, "R8 done holds", done_o, 1);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(dig_en_o == 4'b0, "R1 reset enables", dig_en_o, 0);
      chk(seg_o == 7'h7F, "R1 reset segments", seg_o, 7'h7F);
      chk(done_o == 1'b0, "R1 reset done", done_o, 0);
    end
    // R5 every glyph, directed
    run_session(16'h3210, 0, TOTAL);
    run_session(16'h7654, 0, TOTAL);
    run_session(16'hBA98, 0, TOTAL);
    run_session(16'hFEDC, 0, TOTAL);
    run_session(16'h0000, 1, TOTAL);  // R9 blank throughout, timing kept
    // R10 restart mid-session
    run_session(16'h1111, 0, 2 * DW + 2);
    run_session(16'hA5C3, 0, TOTAL);
    for (int r = 0; r < 8; r++)
      run_session(16'($urandom), (r % 3 == 2) ? 2 : 0, TOTAL);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule